// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides an oscillator clock by a programmable ratio N and emits one registered, single-cycle pulse per N input cycles for a downstream phase/frequency comparator. The ratio is built from three parts. A dual-modulus prescaler divides by 16 or by 17. A 4-bit swallow counter decides how many prescaler cycles use the longer modulus. An 11-bit main counter sets how many prescaler cycles make up one output period. The resulting ratio is N = 16·M + A.

The 15-bit divide word is sampled at reset and again at the end of every output period. A change to the word in the middle of a period therefore takes effect cleanly on the following period. A test-mode select routes a square wave at half the divided rate to an auxiliary output pin. A combinational flag marks divide words whose ratio is not defined.

Top module: `psd_divider`

## Requirements
- R1: For a valid word (1 ≤ M and A ≤ M), consecutive rising edges of `div_pulse` are exactly N = 16·M + A clock cycles apart.
- R2: Within each output period, the prescaler divides by 17 for the first A prescaler cycles and by 16 for the remaining M − A cycles.
- R3: The swallow count A is `div_word[3:0]` and the main count M is `div_word[14:4]`.
- R4: `div_pulse` is high for exactly one clock cycle per output period and comes from a register.
- R5: The divide word is sampled only at reset and on the clock edge that raises `div_pulse`. Changes to the word at any other time do not alter the period in progress.
- R6: `word_bad` is high exactly when the applied word has M < A or M = 0.
- R7: While `rst` is high, `div_pulse` and `aux_out` are 0. After `rst` falls, the first pulse appears on the N-th rising clock edge.
- R8: When `test_en` is 1, `aux_out` changes state on every clock edge that raises `div_pulse`, starting from 0 after reset. When `test_en` is 0, `aux_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| div_word | input | 15 | Divide word: M in bits 14:4, A in bits 3:0 |
| test_en | input | 1 | Selects the half-rate test signal onto `aux_out` |
| div_pulse | output | 1 | One-cycle pulse per output period |
| aux_out | output | 1 | Half-rate square wave in test mode, otherwise 0 |
| word_bad | output | 1 | Applied divide word gives an undefined ratio |

## Verification
Any corruption of the prescaler count or of the swallow or main counters changes the spacing between output pulses. This shows up as a wrong period within one output period, at most about 33,000 cycles and only a few hundred for the small words swept here. Measuring two consecutive periods per word therefore catches a wrong modulus choice, a wrong field split, or a reload at the wrong time. A lost or doubled toggle of the test signal inverts `aux_out` from the next pulse onward. A counter that was not cleared at reset shifts the first pulse away from edge N.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int A_BITS = 4;
  localparam int M_BITS = 11;
  localparam int W_BITS = A_BITS + M_BITS;

  function automatic logic [A_BITS-1:0] swallow_of(input logic [W_BITS-1:0] w);
    return w[A_BITS-1:0];
  endfunction

  function automatic logic [M_BITS-1:0] main_of(input logic [W_BITS-1:0] w);
    return w[W_BITS-1:A_BITS];
  endfunction

  // a ratio is defined only when the main count is nonzero and covers the swallow count
  function automatic logic word_valid(input logic [W_BITS-1:0] w);
    logic [M_BITS-1:0] a_ext;
    a_ext = M_BITS'(swallow_of(w));
    return (main_of(w) != '0) && (main_of(w) >= a_ext);
  endfunction
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int P = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic swallow,
  output logic tick
);
  localparam int CW = $clog2(P + 1);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = swallow ? CW'(P) : CW'(P - 1);
  assign tick = (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(P)); // R2

  AST_MOD16_SHORT: assert property (@(posedge clk) disable iff (rst)
    (!swallow && !tick) |-> cnt_q < CW'(P - 1)); // R2
endmodule

// File: rtl/psd_counters.sv
module psd_counters #(
  parameter int AW = 4,
  parameter int MW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [AW-1:0] a_load,
  input  logic [MW-1:0] m_load,
  input  logic          load_ok,
  output logic          swallow,
  output logic          period_end
);
  logic [AW-1:0] a_q;
  logic [MW-1:0] m_q;
  logic          ok_q;
  logic          reload;

  assign swallow    = (a_q != '0);
  assign period_end = tick && (m_q <= MW'(1));
  assign reload     = rst || period_end;

  always_ff @(posedge clk) begin
    if (reload) begin
      a_q  <= a_load;
      m_q  <= m_load;
      ok_q <= load_ok;
    end else if (tick) begin
      if (swallow) a_q <= a_q - 1'b1;
      m_q <= m_q - 1'b1;
    end
  end

  AST_SWALLOW_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ok_q && swallow) |-> (m_q >= MW'(a_q))); // R2

  AST_MAIN_LIVE: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> (m_q != '0)); // R1
endmodule

// File: rtl/psd_halfrate.sv
module psd_halfrate (
  input  logic clk,
  input  logic rst,
  input  logic period_end,
  input  logic test_en,
  output logic pulse_q,
  output logic aux
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      pulse_q <= period_end;
      half_q  <= half_q ^ period_end;
    end
  end

  assign aux = test_en & half_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q); // R4

  AST_HALF_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> (half_q != $past(half_q))); // R8

  AST_HALF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !pulse_q |-> $stable(half_q)); // R8

  AST_AUX_QUIET: assert property (@(posedge clk)
    !test_en |-> !aux); // R8
endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [W_BITS-1:0] div_word,
  input  logic              test_en,
  output logic              div_pulse,
  output logic              aux_out,
  output logic              word_bad
);
  localparam int P = 1 << A_BITS;

  logic pre_tick;
  logic swallow;
  logic period_end;

  assign word_bad = !word_valid(div_word);

  psd_prescaler #(.P(P)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .swallow (swallow),
    .tick    (pre_tick)
  );

  psd_counters #(.AW(A_BITS), .MW(M_BITS)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (pre_tick),
    .a_load     (swallow_of(div_word)),
    .m_load     (main_of(div_word)),
    .load_ok    (word_valid(div_word)),
    .swallow    (swallow),
    .period_end (period_end)
  );

  psd_halfrate u_half (
    .clk        (clk),
    .rst        (rst),
    .period_end (period_end),
    .test_en    (test_en),
    .pulse_q    (div_pulse),
    .aux        (aux_out)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!div_pulse && !aux_out)); // R7

  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    period_end |-> pre_tick); // R1
endmodule

// File: tb/tb_psd_divider.sv
module tb_psd_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] div_word = '0;
  logic        test_en = 1'b0;
  logic        div_pulse, aux_out, word_bad;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  psd_divider dut (
    .clk(clk), .rst(rst), .div_word(div_word), .test_en(test_en),
    .div_pulse(div_pulse), .aux_out(aux_out), .word_bad(word_bad)
  );

  function automatic int ratio(input int m, input int a);
    return m * 16 + a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges until the pulse is seen
  task automatic meas(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse && n < 40000);
  endtask

  task automatic do_reset(input logic [14:0] w);
    @(negedge clk);
    rst = 1'b1;
    div_word = w;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int n;
    // R7: quiet during reset
    div_word = {11'd3, 4'd2};
    test_en = 1'b1;
    repeat (3) @(negedge clk);
    check(!div_pulse && !aux_out, "R7 reset outputs", {div_pulse, aux_out}, 0);

    // R1 R3 R7: sweep of swallow counts and main counts, word = {M, A}
    for (int a = 0; a < 16; a++) begin
      for (int k = 0; k < 3; k++) begin
        int m;
        m = (k == 0) ? ((a == 0) ? 1 : a) : (k == 1) ? a + 1 : 20;
        do_reset({11'(m), 4'(a)});
        meas(n);
        check(n == ratio(m, a), "R7 first period", n, ratio(m, a));
        @(negedge clk);
        check(!div_pulse, "R4 pulse width", div_pulse, 0);
        meas(n);
        n++;
        check(n == ratio(m, a), "R1 R2 R3 period", n, ratio(m, a));
      end
    end

    // R8: test toggle
    test_en = 1'b1;
    do_reset({11'd2, 4'd1});
    @(negedge clk);
    check(aux_out == 1'b0, "R8 aux after reset", aux_out, 0);
    meas(n);
    check(aux_out == 1'b1, "R8 aux first toggle", aux_out, 1);
    meas(n);
    check(aux_out == 1'b0, "R8 aux second toggle", aux_out, 0);
    check(n == 33, "R1 period M2 A1", n, 33);
    test_en = 1'b0;
    meas(n);
    check(aux_out == 1'b0, "R8 aux off in normal mode", aux_out, 0);

    // R5: change mid-period
    do_reset({11'd4, 4'd3});
    repeat (10) @(negedge clk);
    div_word = {11'd6, 4'd5};
    meas(n);
    n += 10;
    check(n == 67, "R5 old word kept", n, 67);
    meas(n);
    check(n == 101, "R5 new word used", n, 101);

    // R6: invalid word flag
    div_word = {11'd3, 4'd4};
    #1 check(word_bad == 1'b1, "R6 M<A", word_bad, 1);
    div_word = {11'd0, 4'd0};
    #1 check(word_bad == 1'b1, "R6 M=0", word_bad, 1);
    div_word = {11'd4, 4'd4};
    #1 check(word_bad == 1'b0, "R6 M=A", word_bad, 0);
    div_word = {11'd2047, 4'd15};
    #1 check(word_bad == 1'b0, "R6 max word", word_bad, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule